// File: doc/BRIEF.md
# Streaming Sliding-Window Keyword Matcher

This block scans a stream of 8-bit characters for one keyword of 1 to 8 characters. Each accepted character is shifted into a 64-bit history word. The history is then ANDed with a window mask and compared with the keyword value, and the result is a single match bit. Exactly one match bit is produced per accepted character, so every position in the stream is tested.

Characters enter on a valid/ready input. Match bits leave on a valid/ready output through one registered stage. A stalled output holds both the pending bit and the history. In that state no further character is taken, so no character is dropped.

The keyword and the mask are held stable for the whole run. The first keyword character sits in the most significant byte the mask keeps. A clear input empties the history so that a new run can start. The keyword bytes are expected to be non-zero, which means an empty history cannot give a false match.

Top module: `stream_keyword_matcher`

## Requirements
- R1: After synchronous reset, out_valid is 0, in_ready is 1 and the history is all zeros.
- R2: On every accepted character (in_valid and in_ready both high at a clock edge), the history shifts left by 8 bits and the new character enters bits 7:0. As a result, the character accepted earliest occupies the highest of the compared bytes.
- R3: The match bit for an accepted character is 1 exactly when (history after that character AND mask) equals keyword. For a 5-character keyword "HELLO" the keyword value is 0x48454C4C4F and the mask is 0x000000FFFFFFFFFF.
- R4: A keyword of N characters uses a mask covering the low N bytes. The extremes N=1 (mask 0xFF) and N=8 (mask all ones) both match correctly.
- R5: Exactly one match bit is produced per accepted character, and match bits leave in input order. out_valid drops after a handshake that has no new acceptance in the same cycle.
- R6: in_ready is 1 whenever out_valid is 0 or out_ready is 1. With in_valid and out_ready held high, one character is accepted every clock.
- R7: While out_valid is 1 and out_ready is 0, in_ready is 0 and out_match is held. No character is accepted and the history is unchanged.
- R8: clear sets the history to zero and leaves any pending result in place. A character accepted in the same cycle as clear becomes the only character in the new history.
- R9: out_valid is 1 and the character's match bit is presented in the clock cycle after the character is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Empties the history at the next edge |
| in_valid | input | 1 | A character is offered |
| in_ready | output | 1 | The block can take a character this cycle |
| in_char | input | 8 | Offered character |
| keyword | input | 64 | Keyword value, first character in the highest used byte |
| mask | input | 64 | Window mask covering the low N bytes |
| out_valid | output | 1 | A match bit is presented |
| out_ready | input | 1 | Downstream accepts the match bit |
| out_match | output | 1 | Match result for one input position |

## Verification
Two functions can fall in the same clock edge. The first pair is a clear and the acceptance of a character. The second pair is the drain of a pending result and the loading of the next one. A dedicated phase raises clear at random while characters flow and the output stalls at random. In that phase the behavioural model starts the history from only the character accepted on the clear edge. The pending bit taken before the clear must still come out unchanged. A full-throughput phase keeps the input valid and the output ready throughout. Every cycle of that phase must then both drain and reload, and the phase's acceptance count must equal its cycle count.

// File: rtl/skm_pkg.sv
package skm_pkg;
    localparam int CHAR_W    = 8;
    localparam int MAX_CHARS = 8;
    localparam int HIST_W    = CHAR_W * MAX_CHARS;

    typedef logic [CHAR_W-1:0] char_t;
    typedef logic [HIST_W-1:0] hist_t;

    typedef struct packed {
        logic valid;
        logic match;
    } result_t;

    function automatic hist_t shift_in(hist_t h, char_t c);
        return {h[HIST_W-CHAR_W-1:0], c};
    endfunction

    function automatic char_t lane_of(hist_t w, int idx);
        return w[idx*CHAR_W +: CHAR_W];
    endfunction
endpackage

// File: rtl/skm_history.sv
module skm_history
    import skm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  shift_en,
    input  char_t char_in,
    output hist_t hist_q,
    output hist_t hist_next
);
    hist_t base;

    always_comb begin
        base      = clear ? '0 : hist_q;
        hist_next = shift_en ? shift_in(base, char_in) : base;
    end

    always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= hist_next;
    end

    // R2
    shift_order_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !clear) |=> (hist_q[CHAR_W-1:0] == $past(char_in)) &&
                                 (hist_q[HIST_W-1:CHAR_W] == $past(hist_q[HIST_W-CHAR_W-1:0])));
    // R8
    clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (hist_q[HIST_W-1:CHAR_W] == '0));
    // R7
    hold_history_chk: assert property (@(posedge clk) disable iff (rst)
        (!shift_en && !clear) |=> $stable(hist_q));
endmodule

// File: rtl/skm_compare.sv
module skm_compare
    import skm_pkg::*;
(
    input  hist_t window,
    input  hist_t mask,
    input  hist_t keyword,
    output logic  hit
);
    logic [MAX_CHARS-1:0] lane_hit;

    for (genvar i = 0; i < MAX_CHARS; i++) begin : g_lane
        assign lane_hit[i] =
            ((lane_of(window, i) & lane_of(mask, i)) == lane_of(keyword, i));
    end

    assign hit = &lane_hit;
endmodule

// File: rtl/skm_out_stage.sv
module skm_out_stage
    import skm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic load_match,
    input  logic out_ready,
    output logic out_valid,
    output logic out_match,
    output logic room
);
    result_t res_q;

    assign out_valid = res_q.valid;
    assign out_match = res_q.match;
    assign room      = !res_q.valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else if (load) begin
            res_q.valid <= 1'b1;
            res_q.match <= load_match;
        end else if (out_ready) begin
            res_q.valid <= 1'b0;
        end
    end

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_match)));
    // R9
    load_shows_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> out_valid);
    // R5
    drain_drops_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !load) |=> !out_valid);
    // R7
    no_load_stalled_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !load);
endmodule

// File: rtl/stream_keyword_matcher.sv
module stream_keyword_matcher
    import skm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_char,
    input  logic [63:0] keyword,
    input  logic [63:0] mask,
    output logic        out_valid,
    input  logic        out_ready,
    output logic        out_match
);
    logic  accept;
    logic  hit;
    hist_t hist_q;
    hist_t hist_next;

    assign accept = in_valid && in_ready;

    skm_history u_history (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear),
        .shift_en (accept),
        .char_in  (in_char),
        .hist_q   (hist_q),
        .hist_next(hist_next)
    );

    skm_compare u_compare (
        .window (hist_next),
        .mask   (mask),
        .keyword(keyword),
        .hit    (hit)
    );

    skm_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .load_match(hit),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_match (out_match),
        .room      (in_ready)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && hist_q == '0));
    // R6
    throughput_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && out_ready) |-> in_ready);
endmodule

// File: tb/test_stream_keyword_matcher.sv
`timescale 1ns/1ps
module test_stream_keyword_matcher;
    localparam int PH_LEN  = 1500;
    localparam int N_PHASE = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clear = 1'b0;
    logic        in_valid = 1'b0;
    logic        out_ready = 1'b0;
    logic [7:0]  in_char = 8'h00;
    logic [63:0] keyword = 64'h0;
    logic [63:0] mask = 64'h0;
    logic        in_ready, out_valid, out_match;

    stream_keyword_matcher i_stream_keyword_matcher (
        .clk(clk), .rst(rst), .clear(clear),
        .in_valid(in_valid), .in_ready(in_ready), .in_char(in_char),
        .keyword(keyword), .mask(mask),
        .out_valid(out_valid), .out_ready(out_ready), .out_match(out_match)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    bit [63:0] m_hist = 64'h0;
    bit        q[$];
    bit        last_acc = 0;
    int        cyc = 0;
    int        kw_len = 5;
    int        inj = 0;
    int        vprob = 0, rprob = 0, cprob = 0;
    int        acc_in_phase = 0, hits_in_phase = 0;
    string     ptag = "R3";
    int        cur_phase = -1;
    byte       alpha [6] = '{8'h48, 8'h45, 8'h4C, 8'h4F, 8'h41, 8'h42};

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit [63:0] mask_for(int n);
        return (n >= 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'h1 << (8*n)) - 64'h1);
    endfunction

    task automatic end_phase(int p);
        check(hits_in_phase > 0, ptag, "matches seen in phase", hits_in_phase, 1);
        if (p == 4)
            check(acc_in_phase == PH_LEN, "R6", "accepts in full-rate phase",
                  acc_in_phase, PH_LEN);
    endtask

    task automatic start_phase(int p);
        acc_in_phase = 0; hits_in_phase = 0; inj = 0;
        case (p)
            0: begin ptag = "R3"; keyword = 64'h48454C4C4F; kw_len = 5; vprob = 70;  rprob = 70;  cprob = 0;  end
            1: begin ptag = "R2"; keyword = 64'h4142;       kw_len = 2; vprob = 80;  rprob = 60;  cprob = 0;  end
            2: begin ptag = "R4"; keyword = 64'h4F;         kw_len = 1; vprob = 75;  rprob = 75;  cprob = 0;  end
            3: begin ptag = "R4"; keyword = 64'h48454C4C4F414245; kw_len = 8; vprob = 80; rprob = 80; cprob = 0; end
            4: begin ptag = "R6"; keyword = 64'h48454C4C4F; kw_len = 5; vprob = 100; rprob = 100; cprob = 0;  end
            5: begin ptag = "R8"; keyword = 64'h48454C4C4F; kw_len = 5; vprob = 90;  rprob = 70;  cprob = 10; end
            default: begin ptag = "R7"; keyword = 64'h48454C4C4F; kw_len = 5; vprob = 80; rprob = 20; cprob = 0; end
        endcase
        mask = mask_for(kw_len);
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc <= 3) begin
            rst = 1'b1; clear = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
            m_hist = 64'h0; q.delete(); last_acc = 0;
        end else if (!done) begin
            bit exp_valid;
            bit rdy, acc;
            int p, off;
            rst = 1'b0;
            exp_valid = (q.size() != 0);
            if (cyc == 4) begin
                check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
                check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
            end else begin
                check(out_valid == exp_valid, last_acc ? "R9" : "R5", "out_valid",
                      out_valid, exp_valid);
                if (exp_valid && out_valid)
                    check(out_match == q[0], ptag, "out_match", out_match, q[0]);
                check(in_ready == (!exp_valid || out_ready),
                      (exp_valid && !out_ready) ? "R7" : "R6", "in_ready",
                      in_ready, (!exp_valid || out_ready));
            end

            off = cyc - 5;
            p   = (off < 0) ? -1 : off / PH_LEN;
            clear = 1'b0;
            if (p != cur_phase) begin
                if (cur_phase >= 0) end_phase(cur_phase);
                cur_phase = p;
                if (p >= N_PHASE) begin
                    done = 1;
                    in_valid = 1'b0; out_ready = 1'b0;
                end else if (p >= 0) begin
                    start_phase(p);
                    clear = 1'b1;
                end
            end

            if (!done) begin
                if (p < 0) begin
                    in_valid = 1'b0; out_ready = 1'b1;
                end else begin
                    in_valid  = ($urandom % 100) < vprob;
                    out_ready = ($urandom % 100) < rprob;
                    if (cprob > 0 && ($urandom % 100) < cprob) clear = 1'b1;
                    if (inj == 0 && ($urandom % 100) < 15) inj = kw_len;
                    if (inj > 0) in_char = keyword[8*(inj-1) +: 8];
                    else         in_char = alpha[$urandom % 6];
                end

                rdy = (q.size() == 0) || out_ready;
                acc = in_valid && rdy;
                if (q.size() != 0 && out_ready) begin
                    if (q[0]) hits_in_phase++;
                    void'(q.pop_front());
                end
                if (clear) m_hist = 64'h0;
                if (acc) begin
                    m_hist = {m_hist[55:0], in_char};
                    q.push_back((m_hist & mask) == keyword);
                    acc_in_phase++;
                    if (inj > 0) inj--;
                end
                last_acc = acc;
            end
        end
    end

    initial begin
        wait (done);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule